// File: doc/BRIEF.md
# Flash Status Register with Sticky Errors

This block holds the eight-bit status byte that a flash-style command interface presents to its host. It follows the write engine through its life cycle: busy, idle, suspended and resumed. It records program, erase, supply and lock faults in sticky flags that stay set until software explicitly clears them. Command decoding and the storage array sit outside the block. Their results reach it as single-cycle event pulses: operation start, completion, failure, suspend complete and resume. A level flag reports whether the supply is in range.

The host reads status through two active-low strobes, a chip enable and an output enable, which are sampled in the block's clock domain. The byte is copied into a snapshot on the clock edge that first sees both strobes low, which is the edge after the later of the two falls. The snapshot is held for as long as both stay low, so a read never shows a byte that changes mid-cycle. A fresh value appears only after one strobe has gone high and then low again.

Top module: `flash_status_reg`

## Requirements
- R1: After a synchronous reset the status byte is 0x80: ready (bit 7) set, every other bit clear.
- R2: A start pulse while bit 7 is 1 and the supply flag is high clears bit 7 on the next edge. A done pulse while busy sets bit 7 again. A start while busy is ignored.
- R3: A fail pulse while busy sets bit 7 and a sticky failure flag: bit 4 for a program, bit 5 for an erase. The kind is the one given by the erase-select input at start.
- R4: A suspend-complete pulse while busy sets bit 7 and sets bit 2 (program) or bit 6 (erase). A resume pulse while ready with a suspend flag set clears both bits 2 and 6 and clears bit 7.
- R5: A locked-target pulse sets sticky bit 1.
- R6: A start while the supply flag is low does not start the engine, so bit 7 stays 1. It sets bit 3, and it also sets bit 5 for an erase or bit 4 for a program.
- R7: Bits 1, 3, 4 and 5 are never cleared by completion, new starts, suspend or resume. Only the clear pulse or reset clears them.
- R8: The clear pulse zeroes bits 1, 3, 4 and 5 and leaves bits 7, 6 and 2 unchanged. A flag set in the same cycle as a clear ends up set.
- R9: The read word is 0x0000 while either strobe is high. While selected, bits 15..8 and bit 0 read 0, and bits 7..1 carry the status.
- R10: The snapshot is taken on the first edge where both strobes are low, whichever strobe fell last. It is held unchanged while both stay low, even if the status changes.
- R11: A new status value becomes visible only after a strobe rises and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Operation start pulse |
| op_erase | input | 1 | Kind of the starting operation: 1 erase, 0 program |
| op_done | input | 1 | Operation finished successfully |
| op_fail | input | 1 | Operation finished with failure |
| susp_done | input | 1 | Suspend of the running operation has completed |
| resume | input | 1 | Suspended operation resumes |
| supply_ok | input | 1 | Supply voltage in range |
| lock_hit | input | 1 | Attempt on a locked target |
| clr_err | input | 1 | Clear-status command pulse |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| rd_word | output | 16 | Status read word |

## Verification
The assertions check on every cycle that the error flags never fall without a clear, and that an accepted start drops ready. They also check that a locked-target pulse or a bad-supply erase sets its flags, that the snapshot copies the live byte on a select edge, and that it is frozen while the host stays selected. The bench scenarios are the only way to show the complete byte sequences. These include a fault record surviving later successful operations, which flag a suspend picks for each kind, the exact 0x0000 deselected word, and that a read with the strobes in either order returns the same value.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int BUS_W = 16;

    // Bit order is fixed by the host-visible byte layout (bit 7 first).
    typedef struct packed {
        logic ready;    // 7
        logic esusp;    // 6
        logic efail;    // 5
        logic pfail;    // 4
        logic vlow;     // 3
        logic psusp;    // 2
        logic lockerr;  // 1
        logic rsvd;     // 0
    } status_t;

    localparam int STAT_W = $bits(status_t);

    localparam logic [STAT_W-1:0] STICKY_MASK = 8'b0011_1010;

    function automatic status_t drop_errors(status_t s);
        return status_t'(s & ~STICKY_MASK);
    endfunction

    function automatic logic [BUS_W-1:0] to_word(status_t s);
        logic [STAT_W-1:0] b;
        b = s;
        b[0] = 1'b0;
        return {{(BUS_W-STAT_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/fsr_core.sv
module fsr_core
    import fsr_pkg::*;
#(
    parameter logic [STAT_W-1:0] RESET_VAL = 8'h80
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    op_start,
    input  logic    op_erase,
    input  logic    op_done,
    input  logic    op_fail,
    input  logic    susp_done,
    input  logic    resume,
    input  logic    supply_ok,
    input  logic    lock_hit,
    input  logic    clr_err,
    output status_t st_o
);

    status_t st_q, st_d;
    logic    kind_q, kind_d;   // 1 = erase in flight
    logic    accept;

    assign accept = op_start && st_q.ready;

    always_comb begin
        st_d   = st_q;
        kind_d = kind_q;
        if (clr_err) st_d = drop_errors(st_d);

        if (accept) begin
            if (!supply_ok) begin
                st_d.vlow = 1'b1;
                if (op_erase) st_d.efail = 1'b1;
                else          st_d.pfail = 1'b1;
            end else begin
                st_d.ready = 1'b0;
                kind_d     = op_erase;
            end
        end else if (!st_q.ready) begin
            if (op_done || op_fail) begin
                st_d.ready = 1'b1;
                if (op_fail) begin
                    if (kind_q) st_d.efail = 1'b1;
                    else        st_d.pfail = 1'b1;
                end
            end else if (susp_done) begin
                st_d.ready = 1'b1;
                if (kind_q) st_d.esusp = 1'b1;
                else        st_d.psusp = 1'b1;
            end
        end else if (resume && (st_q.esusp || st_q.psusp)) begin
            st_d.ready = 1'b0;
            kind_d     = !st_q.psusp;
            st_d.esusp = 1'b0;
            st_d.psusp = 1'b0;
        end

        if (lock_hit) st_d.lockerr = 1'b1;
        st_d.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= status_t'(RESET_VAL);
            kind_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
        end
    end

    assign st_o = st_q;

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_err |=> ((($past(st_q) & STICKY_MASK) & ~st_q) == '0));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (op_start && st_q.ready && supply_ok) |=> !st_q.ready);

    // R6
    bad_supply_erase_chk: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_erase && st_q.ready && !supply_ok)
            |=> (st_q.ready && st_q.vlow && st_q.efail));

    // R5
    lock_flag_chk: assert property (@(posedge clk) disable iff (rst)
        lock_hit |=> st_q.lockerr);

endmodule

// File: rtl/fsr_snap.sv
module fsr_snap
    import fsr_pkg::*;
#(
    parameter logic [STAT_W-1:0] RESET_VAL = 8'h80
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_n,
    input  logic    oe_n,
    input  status_t live,
    output status_t snap_o,
    output logic    sel_o
);

    status_t snap_q;
    logic    sel_q;
    logic    both_low;

    assign both_low = !ce_n && !oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= status_t'(RESET_VAL);
            sel_q  <= 1'b0;
        end else begin
            sel_q <= both_low;
            if (both_low && !sel_q) snap_q <= live;
        end
    end

    assign snap_o = snap_q;
    assign sel_o  = sel_q;

    // R10
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (both_low && !sel_q) |=> (snap_q == $past(live)));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (both_low && sel_q) |=> $stable(snap_q));

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import fsr_pkg::*;
#(
    parameter logic [STAT_W-1:0] RESET_VAL = 8'h80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_start,
    input  logic             op_erase,
    input  logic             op_done,
    input  logic             op_fail,
    input  logic             susp_done,
    input  logic             resume,
    input  logic             supply_ok,
    input  logic             lock_hit,
    input  logic             clr_err,
    input  logic             ce_n,
    input  logic             oe_n,
    output logic [BUS_W-1:0] rd_word
);

    status_t live_st, snap_st;
    logic    sel;

    fsr_core #(.RESET_VAL(RESET_VAL)) u_core (
        .clk(clk), .rst(rst), .op_start(op_start), .op_erase(op_erase),
        .op_done(op_done), .op_fail(op_fail), .susp_done(susp_done),
        .resume(resume), .supply_ok(supply_ok), .lock_hit(lock_hit),
        .clr_err(clr_err), .st_o(live_st)
    );

    fsr_snap #(.RESET_VAL(RESET_VAL)) u_snap (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n),
        .live(live_st), .snap_o(snap_st), .sel_o(sel)
    );

    assign rd_word = sel ? to_word(snap_st) : '0;

endmodule

// File: tb/tb_flash_status_reg.sv
`timescale 1ns/1ps
module tb_flash_status_reg;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_start = 0, op_erase = 0, op_done = 0, op_fail = 0;
    logic susp_done = 0, resume = 0, supply_ok = 1, lock_hit = 0, clr_err = 0;
    logic ce_n = 1, oe_n = 1;
    logic [15:0] rd_word;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    flash_status_reg dut (
        .clk(clk), .rst(rst), .op_start(op_start), .op_erase(op_erase),
        .op_done(op_done), .op_fail(op_fail), .susp_done(susp_done),
        .resume(resume), .supply_ok(supply_ok), .lock_hit(lock_hit),
        .clr_err(clr_err), .ce_n(ce_n), .oe_n(oe_n), .rd_word(rd_word)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_stat(output logic [15:0] v);
        ce_n = 0; step();
        oe_n = 0; step();
        v = rd_word;
        ce_n = 1; oe_n = 1; step();
    endtask

    task automatic read_oe_first(output logic [15:0] v);
        oe_n = 0; step();
        ce_n = 0; step();
        v = rd_word;
        ce_n = 1; oe_n = 1; step();
    endtask

    task automatic start_op(input logic erase);
        op_start = 1; op_erase = erase; step();
        op_start = 0; op_erase = 0;
    endtask

    task automatic clear();
        clr_err = 1; step(); clr_err = 0;
    endtask

    logic [15:0] v, v1, v2;

    initial begin
        step(); step();
        rst = 0; step();
        // R9: deselected word is zero
        chk(rd_word, 16'h0000, "R9 deselected");
        read_stat(v);
        chk(v, 16'h0080, "R1 reset value");

        // Sweep kinds x outcomes
        for (int k = 0; k < 2; k++) begin
            for (int f = 0; f < 2; f++) begin
                start_op(k[0]);
                read_stat(v);
                chk(v, 16'h0000, "R2 busy after start");
                start_op(~k[0]);           // ignored while busy
                if (f == 1) begin op_fail = 1; step(); op_fail = 0; end
                else        begin op_done = 1; step(); op_done = 0; end
                read_stat(v);
                chk(v, 16'h0080 | (f == 1 ? (k == 1 ? 16'h0020 : 16'h0010) : 16'h0000),
                    f == 1 ? "R3 fail flag" : "R2 ready after done");
                clear();
                read_stat(v);
                chk(v, 16'h0080, "R8 clear");
            end
        end

        // Suspend / resume per kind
        for (int k = 0; k < 2; k++) begin
            start_op(k[0]);
            susp_done = 1; step(); susp_done = 0;
            read_stat(v);
            chk(v, 16'h0080 | (k == 1 ? 16'h0040 : 16'h0004), "R4 suspend flag");
            resume = 1; step(); resume = 0;
            read_stat(v);
            chk(v, 16'h0000, "R4 resume clears");
            op_done = 1; step(); op_done = 0;
            read_stat(v);
            chk(v, 16'h0080, "R4 done after resume");
        end

        // Lock flag and stickiness
        lock_hit = 1; step(); lock_hit = 0;
        read_stat(v);
        chk(v, 16'h0082, "R5 lock flag");
        start_op(1'b0);
        susp_done = 1; step(); susp_done = 0;
        resume = 1; step(); resume = 0;
        op_done = 1; step(); op_done = 0;
        read_stat(v);
        chk(v, 16'h0082, "R7 sticky through op");
        clear();

        // Bad supply per kind
        for (int k = 0; k < 2; k++) begin
            supply_ok = 0;
            start_op(k[0]);
            supply_ok = 1;
            read_stat(v);
            chk(v, 16'h0088 | (k == 1 ? 16'h0020 : 16'h0010), "R6 bad supply");
            clear();
        end

        // Clear and set in same cycle; clear keeps suspend bits
        clr_err = 1; lock_hit = 1; step(); clr_err = 0; lock_hit = 0;
        read_stat(v);
        chk(v, 16'h0082, "R8 set wins over clear");
        start_op(1'b1);
        susp_done = 1; step(); susp_done = 0;
        clear();
        read_stat(v);
        chk(v, 16'h00C0, "R8 clear keeps suspend");
        resume = 1; step(); resume = 0;
        op_done = 1; step(); op_done = 0;

        // Snapshot ordering and hold
        read_oe_first(v);
        chk(v, 16'h0080, "R10 oe falls first");
        ce_n = 0; step();
        oe_n = 0; step();
        v1 = rd_word;
        chk(v1, 16'h0080, "R10 snapshot");
        lock_hit = 1; step(); lock_hit = 0; step();
        v2 = rd_word;
        chk(v2, 16'h0080, "R10 held while selected");
        chk({8'h00, v2[15:8]}, 16'h0000, "R9 upper byte zero");
        ce_n = 1; step();
        chk(rd_word, 16'h0000, "R9 deselected mid-read");
        ce_n = 0; step();
        chk(rd_word, 16'h0082, "R11 new value after toggle");
        ce_n = 1; oe_n = 1; step();
        clear();
        read_stat(v);
        chk(v, 16'h0080, "R8 final clear");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule